// File: doc/BRIEF.md
# Register-Transfer CPU Core

This block is the execution core of a small 8-bit processor. It receives one instruction byte per clock cycle and carries it out in that cycle. The core holds six 8-bit general registers, reads an 8-bit input byte and drives an 8-bit output byte with a one-cycle valid strobe. Fetch, sequencing and branching are left to the surrounding logic. The core executes one instruction per cycle, chosen by the top two instruction bits: load a small constant, run an ALU operation, move a value, or a test class that the core takes in without acting on it.

Moves name a source and a destination with the same 3-bit address code. Codes 0 to 5 select the registers. Code 6 selects the input byte when it is the source and the output byte when it is the destination. Code 7 selects nothing. Arithmetic and logic always read registers 1 and 2 and always write register 3. Register contents leave the core only by moving them to the output address.

Top module: `xfer_cpu_core`

## Requirements
- R1: Instruction fields are destination address in bits [2:0], source address in bits [5:3] and class in bits [7:6], with class codes 00 immediate, 01 calculate, 10 move and 11 test. At most one register is written per cycle.
- R2: A move whose source and destination are both in 0..5 copies register[source] into register[destination] at the next rising edge. All other registers keep their values.
- R3: A move with source address 6 takes the value present on `in_data` in the same cycle as the instruction.
- R4: A move with destination address 6 loads the moved value into `out_data` and raises `out_valid` for exactly the following cycle. In every other case `out_valid` is 0 and `out_data` holds its value.
- R5: A move with source address 7 or destination address 7 changes no register, leaves `out_data` unchanged and keeps `out_valid` at 0.
- R6: A calculate instruction writes f(register 1, register 2) into register 3, where f is selected by bits [2:0]: 000 OR, 001 NAND, 010 NOR, 011 AND, 100 sum mod 256, 101 register 1 minus register 2 mod 256, 110 and 111 give 0. No other register and not the output changes.
- R7: An immediate instruction writes bits [5:0], zero-extended to 8 bits, into register 0. No other register changes.
- R8: A test-class instruction changes no register and no output, and keeps `out_valid` at 0.
- R9: While synchronous reset is high at a rising edge, all six registers and `out_data` become 0 and `out_valid` becomes 0.
- R10: `in_data` has no effect on any register or output unless the instruction is a move with source address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_in | input | 8 | Instruction executed at the next rising edge |
| in_data | input | 8 | Input byte, readable as move source address 6 |
| out_data | output | 8 | Output byte, written by moves to address 6 |
| out_valid | output | 1 | High for one cycle after `out_data` is written |

## Verification
Every result is due at the first rising edge after the instruction is applied. Register writes and the `out_data`/`out_valid` update both appear in the cycle that follows the instruction. A register value is seen at the ports one cycle later still, through a move to address 6. The bench changes `insn_in` and `in_data` on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It compares the ports with a bench model that steps once per instruction. At intervals it moves each register out to address 6 so that the whole register state is compared.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic [1:0] {
      CLS_IMM  = 2'b00,
      CLS_CALC = 2'b01,
      CLS_MOVE = 2'b10,
      CLS_TEST = 2'b11
   } insn_class_t;

   typedef enum logic [2:0] {
      OP_OR   = 3'd0,
      OP_NAND = 3'd1,
      OP_NOR  = 3'd2,
      OP_AND  = 3'd3,
      OP_ADD  = 3'd4,
      OP_SUB  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } alu_op_t;

   typedef enum logic [1:0] {
      WD_NONE = 2'd0,
      WD_IMM  = 2'd1,
      WD_ALU  = 2'd2,
      WD_MOVE = 2'd3
   } wdata_sel_t;

endpackage

// File: rtl/xfer_alu.sv
module xfer_alu
   import xfer_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit SHARED_ADDER  = 1'b1
) (
   input  alu_op_t            op,
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   output logic [DATA_W-1:0]  y
);

   logic [DATA_W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder; subtraction adds the two's complement of b
         logic [DATA_W-1:0] b_eff;
         assign b_eff = (op == OP_SUB) ? (~b + DATA_W'(1)) : b;
         assign arith = a + b_eff;
      end else begin : g_split
         assign arith = (op == OP_SUB) ? (a - b) : (a + b);
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_OR:           y = a | b;
         OP_NAND:         y = ~(a & b);
         OP_NOR:          y = ~(a | b);
         OP_AND:          y = a & b;
         OP_ADD, OP_SUB:  y = arith;
         default:         y = '0;
      endcase
   end

endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
   import xfer_pkg::*;
#(
   parameter int INSN_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int NUM_REGS = 6,
   parameter int IMM_IDX  = 0,
   parameter int RES_IDX  = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [INSN_W-1:0]   insn,
   output insn_class_t         cls,
   output logic [ADDR_W-1:0]   src,
   output logic                src_io,
   output logic [NUM_REGS-1:0] reg_we,
   output logic                out_we,
   output wdata_sel_t          wsel
);

   localparam logic [ADDR_W-1:0] IO_ADDR = ADDR_W'(NUM_REGS);

   logic [ADDR_W-1:0] dst;
   logic              move_ok;

   assign cls     = insn_class_t'(insn[INSN_W-1 -: 2]);
   assign dst     = insn[ADDR_W-1:0];
   assign src     = insn[2*ADDR_W-1:ADDR_W];
   // address decoders only live during a move, and only for codes up to IO
   assign move_ok = (cls == CLS_MOVE) && (src <= IO_ADDR) && (dst <= IO_ADDR);
   assign src_io  = move_ok && (src == IO_ADDR);
   assign out_we  = move_ok && (dst == IO_ADDR);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
         assign reg_we[i] = (move_ok && (dst == ADDR_W'(i)))
                          || ((cls == CLS_IMM)  && (i == IMM_IDX))
                          || ((cls == CLS_CALC) && (i == RES_IDX));
      end
   endgenerate

   always_comb begin
      unique case (cls)
         CLS_IMM:  wsel = WD_IMM;
         CLS_CALC: wsel = WD_ALU;
         CLS_MOVE: wsel = move_ok ? WD_MOVE : WD_NONE;
         default:  wsel = WD_NONE;
      endcase
   end

   assert_one_write_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(reg_we));

   assert_io_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (reg_we == '0));

endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 6
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REGS-1:0]              we,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
         end

         assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> $stable(q[i]));
      end
   endgenerate

endmodule

// File: rtl/xfer_cpu_core.sv
module xfer_cpu_core
   import xfer_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 3,
   parameter int NUM_REGS      = 6,
   parameter int IMM_IDX       = 0,
   parameter int OPA_IDX       = 1,
   parameter int OPB_IDX       = 2,
   parameter int RES_IDX       = 3,
   parameter bit SHARED_ADDER  = 1'b1,
   localparam int INSN_W       = 2 + 2*ADDR_W,
   localparam int IMM_W        = INSN_W - 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [INSN_W-1:0] insn_in,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid
);

   localparam logic [ADDR_W-1:0] IO_ADDR = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] NIL_ADDR = '1;

   initial begin
      assert (ADDR_W >= 3) else $error("ADDR_W must hold a 3-bit ALU op code");
      assert (NUM_REGS < (1 << ADDR_W)) else $error("no address left for the I/O port");
      assert (DATA_W >= IMM_W) else $error("immediate wider than data path");
      assert (IMM_IDX < NUM_REGS && OPA_IDX < NUM_REGS &&
              OPB_IDX < NUM_REGS && RES_IDX < NUM_REGS)
         else $error("fixed register index out of range");
   end

   insn_class_t                     cls;
   logic [ADDR_W-1:0]               src;
   logic                            src_io;
   logic [NUM_REGS-1:0]             reg_we;
   logic                            out_we;
   wdata_sel_t                      wsel;
   logic [NUM_REGS-1:0][DATA_W-1:0] q;
   logic [DATA_W-1:0]               alu_y;
   logic [DATA_W-1:0]               move_val;
   logic [DATA_W-1:0]               wdata;

   xfer_decode #(
      .INSN_W(INSN_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
      .IMM_IDX(IMM_IDX), .RES_IDX(RES_IDX)
   ) u_dec (
      .clk(clk), .rst(rst), .insn(insn_in), .cls(cls), .src(src),
      .src_io(src_io), .reg_we(reg_we), .out_we(out_we), .wsel(wsel)
   );

   xfer_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
      .clk(clk), .rst(rst), .we(reg_we), .wdata(wdata), .q(q)
   );

   // operands come straight from the register outputs, no read enable
   xfer_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op(alu_op_t'(insn_in[2:0])), .a(q[OPA_IDX]), .b(q[OPB_IDX]), .y(alu_y)
   );

   always_comb begin
      move_val = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (src == ADDR_W'(i)) move_val = q[i];
      if (src_io) move_val = in_data;
   end

   always_comb begin
      unique case (wsel)
         WD_IMM:  wdata = DATA_W'(insn_in[IMM_W-1:0]);
         WD_ALU:  wdata = alu_y;
         WD_MOVE: wdata = move_val;
         default: wdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= out_we;
         if (out_we) out_data <= move_val;
      end
   end

   logic is_out_move;
   assign is_out_move = (insn_in[INSN_W-1 -: 2] == 2'b10)
                      && (insn_in[ADDR_W-1:0] == IO_ADDR)
                      && (insn_in[2*ADDR_W-1:ADDR_W] != NIL_ADDR);

   assert_out_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      is_out_move |=> out_valid);

   assert_out_cause_R4: assert property (@(posedge clk) disable iff (rst)
      !is_out_move |=> (!out_valid && $stable(out_data)));

   assert_calc_add_R6: assert property (@(posedge clk) disable iff (rst)
      (insn_in[INSN_W-1 -: 2] == 2'b01 && insn_in[2:0] == 3'b100)
      |=> (q[RES_IDX] == $past(q[OPA_IDX] + q[OPB_IDX])));

   assert_imm_load_R7: assert property (@(posedge clk) disable iff (rst)
      (insn_in[INSN_W-1 -: 2] == 2'b00)
      |=> (q[IMM_IDX] == DATA_W'($past(insn_in[IMM_W-1:0]))));

   assert_test_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (insn_in[INSN_W-1 -: 2] == 2'b11) |=> ($stable(q) && !out_valid));

endmodule

// File: tb/xfer_cpu_core_test.sv
`timescale 1ns/1ps
module xfer_cpu_core_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] insn_in = 8'h00;
   logic [7:0] in_data = 8'h00;
   logic [7:0] out_data;
   logic       out_valid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] m_reg [6];
   logic [7:0] m_out;
   logic       m_vld;

   always #5 clk = ~clk;

   xfer_cpu_core uut (
      .clk(clk), .rst(rst), .insn_in(insn_in), .in_data(in_data),
      .out_data(out_data), .out_valid(out_valid)
   );

   function automatic logic [7:0] alu_ref(input logic [2:0] op,
                                          input logic [7:0] a,
                                          input logic [7:0] b);
      case (op)
         3'd0:    return a | b;
         3'd1:    return ~(a & b);
         3'd2:    return ~(a | b);
         3'd3:    return a & b;
         3'd4:    return a + b;
         3'd5:    return a - b;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] ins);
      case (ins[7:6])
         2'b00:   return "R7";
         2'b01:   return "R6";
         2'b10:   return (ins[5:3] == 3'd7 || ins[2:0] == 3'd7) ? "R5" : "R2";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                      input string tag, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
      m_out = 8'h00;
      m_vld = 1'b0;
   endtask

   task automatic model_step(input logic [7:0] ins, input logic [7:0] din);
      logic [7:0] v;
      m_vld = 1'b0;
      case (ins[7:6])
         2'b00: m_reg[0] = {2'b00, ins[5:0]};
         2'b01: m_reg[3] = alu_ref(ins[2:0], m_reg[1], m_reg[2]);
         2'b10: if (ins[5:3] != 3'd7 && ins[2:0] != 3'd7) begin
            v = (ins[5:3] == 3'd6) ? din : m_reg[ins[5:3]];
            if (ins[2:0] == 3'd6) begin
               m_out = v;
               m_vld = 1'b1;
            end else begin
               m_reg[ins[2:0]] = v;
            end
         end
         default: ;
      endcase
   endtask

   // inputs change on the falling edge; results sampled one falling edge later
   task automatic step(input logic [7:0] ins, input logic [7:0] din, input string tag);
      insn_in = ins;
      in_data = din;
      model_step(ins, din);
      @(posedge clk);
      @(negedge clk);
      chk({7'd0, out_valid}, {7'd0, m_vld}, tag, "out_valid");
      chk(out_data, m_out, tag, "out_data");
   endtask

   task automatic dump_regs(input string tag);
      for (int r = 0; r < 6; r++)
         step({2'b10, 3'(r), 3'd6}, 8'($urandom), tag);
   endtask

   task automatic load_reg(input int r, input logic [7:0] v);
      step({2'b10, 3'd6, 3'(r)}, v, "R3");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9: state after reset
      chk({7'd0, out_valid}, 8'h00, "R9", "out_valid after reset");
      chk(out_data, 8'h00, "R9", "out_data after reset");
      dump_regs("R9");

      // R7: immediate, zero-extended into register 0
      step(8'h3F, 8'hAA, "R7");
      dump_regs("R7");
      step(8'h15, 8'h55, "R7");

      // R3/R4: input straight to output, and to registers
      step(8'b10_110_110, 8'hC3, "R3");
      step(8'b00_000_001, 8'h77, "R4");
      for (int r = 0; r < 6; r++) load_reg(r, 8'(8'h11 * (r + 1)));
      dump_regs("R3");

      // R2: register to register
      step(8'b10_101_000, 8'h00, "R2");
      step(8'b10_000_100, 8'h00, "R2");
      dump_regs("R2");

      // R5: address 7 on either side
      step(8'b10_111_011, 8'hEE, "R5");
      step(8'b10_010_111, 8'hEE, "R5");
      step(8'b10_111_111, 8'hEE, "R5");
      dump_regs("R5");

      // R6: every op code, including carry-out and borrow
      load_reg(1, 8'hF0);
      load_reg(2, 8'h20);
      for (int op = 0; op < 8; op++) begin
         step({2'b01, 3'd0, 3'(op)}, 8'h99, "R6");
         step({2'b10, 3'd3, 3'd6}, 8'h00, "R6");
      end
      load_reg(1, 8'h05);
      load_reg(2, 8'h07);
      step(8'b01_000_101, 8'h00, "R6");
      step(8'b10_011_110, 8'h00, "R6");
      dump_regs("R6");

      // R8 and R10: test class with busy input bus
      step(8'hFF, 8'h5A, "R8");
      step(8'hC6, 8'hA5, "R10");
      dump_regs("R8");

      // R1 + R10: random mix against the model
      for (int n = 0; n < 400; n++) begin
         logic [7:0] ins;
         ins = 8'($urandom);
         step(ins, 8'($urandom), tag_of(ins));
         if (n % 50 == 49) dump_regs("R1");
      end
      dump_regs("R10");

      // R9: reset in the middle of a run
      insn_in = 8'b10_110_000;
      in_data = 8'hFF;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk({7'd0, out_valid}, 8'h00, "R9", "out_valid mid reset");
      chk(out_data, 8'h00, "R9", "out_data mid reset");
      dump_regs("R9");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule